// File: doc/BRIEF.md
# Continuous-Phase MSK Tone Modulator

This block turns a serial bit stream into a digital minimum-shift-keyed waveform. It runs from a 3.6864 MHz master clock. It produces its own transmit bit clock, and it takes the serial data input on the rising edge of that clock. Each bit selects one of two tones. The block synthesizes the tone with a phase accumulator that is never cleared while the modulator runs, so the waveform has no phase jump at a bit boundary.

A rate-select input chooses the bit rate:
- Low rate (0): 1200 bit/s. The tones are 1200 Hz and 1800 Hz.
- High rate (1): 2400 bit/s. The tones are 1200 Hz and 2400 Hz.

Samples are 8-bit signed values. They come from a quarter-wave sine table and are issued at 9600 samples per second, each with a one-cycle strobe. A DAC and the analog shaping that follows take these samples.

When the enable input is low:
- the bit clock is held high;
- the sample output rests at zero;
- no strobes are issued.

Top module: `msk_tone_mod`

## Requirements
- R1: While enabled, `sample_stb` pulses once every 384 master clocks (3.6864 MHz / 9600). `sample_out` holds the new sample in the cycle of each pulse.
- R2: Each bit lasts 3072 master clocks at `rate_sel`=0 and 1536 master clocks at `rate_sel`=1. `tx_bit_clk` is low for the first half of a bit and high for the second half.
- R3: `tx_data` is sampled at the rising edge of `tx_bit_clk`. The sampled value sets the tone of the following bit. The first bit after enabling carries data 0.
- R4: A bit of value 0 gives 1200 Hz. A bit of value 1 gives 1800 Hz at `rate_sel`=0 and 2400 Hz at `rate_sel`=1. The phase step per sample is f·65536/9600, which is exact, so every tone is within 1 Hz of nominal.
- R5: Phase is continuous. The accumulator advances by one step per sample, is never cleared while enabled, and changes its step only at a bit boundary.
- R6: While `mod_en`=0, `tx_bit_clk` is 1 from the next clock on.
- R7: While `mod_en`=0, `sample_out` is 0 and `sample_stb` stays low. The phase restarts at 0, so the first sample after enabling is 0.
- R8: `sample_out` is two's complement and equals round(127·sin(2π·φ/65536)), where φ is the 16-bit accumulator value before the step. The value comes from a 17-entry quarter-wave table addressed by the top six phase bits.
- R9: During synchronous reset, `tx_bit_clk`=1, `sample_out`=0 and `sample_stb`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.6864 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | Modulator enable |
| rate_sel | input | 1 | 0: 1200 bit/s, 1: 2400 bit/s |
| tx_data | input | 1 | Serial transmit data |
| tx_bit_clk | output | 1 | Transmit bit clock; data is taken on its rising edge |
| sample_out | output | 8 | Signed sine sample |
| sample_stb | output | 1 | One-cycle pulse marking a new sample |

## Verification
The assertions assume that `rate_sel` changes only while `mod_en` is low, since a mid-stream rate change would split a bit irregularly. They also assume that `tx_data` is stable at each rising edge of `tx_bit_clk`. The bench sets the rate only while the modulator is off. It changes `tx_data` on a falling clock edge right after it sees a rising edge of the bit clock, which leaves a whole bit period of setup. Within those limits the bench keeps its own phase model and checks every sample, including the samples that cross each tone change.

// File: rtl/msk_pkg.sv
package msk_pkg;

    localparam int SAMPLE_W = 8;
    localparam int LUT_AW   = 6;

    typedef enum logic {
        RATE_LO = 1'b0,
        RATE_HI = 1'b1
    } rate_e;

    typedef struct packed {
        logic tick;   // sample instant
        logic mid;    // mid-bit: bit clock rises, data captured
        logic bnd;    // bit boundary: bit clock falls, step switches
    } tmg_evt_t;

    // round(127*sin(i*pi/32)), i = 0..16
    function automatic logic [SAMPLE_W-1:0] quarter_mag(input logic [4:0] i);
        case (i)
            5'd0:  return 8'd0;
            5'd1:  return 8'd12;
            5'd2:  return 8'd25;
            5'd3:  return 8'd37;
            5'd4:  return 8'd49;
            5'd5:  return 8'd60;
            5'd6:  return 8'd71;
            5'd7:  return 8'd81;
            5'd8:  return 8'd90;
            5'd9:  return 8'd98;
            5'd10: return 8'd106;
            5'd11: return 8'd112;
            5'd12: return 8'd117;
            5'd13: return 8'd122;
            5'd14: return 8'd125;
            5'd15: return 8'd126;
            default: return 8'd127;
        endcase
    endfunction

    function automatic logic [SAMPLE_W-1:0] sine_lookup(input logic [LUT_AW-1:0] p);
        logic [4:0]          off;
        logic [SAMPLE_W-1:0] mag;
        off = p[4] ? (5'd16 - {1'b0, p[3:0]}) : {1'b0, p[3:0]};
        mag = quarter_mag(off);
        return p[5] ? (~mag + 8'd1) : mag;
    endfunction

endpackage

// File: rtl/msk_timing.sv
module msk_timing
    import msk_pkg::*;
#(
    parameter int SDIV   = 384,
    parameter int SPB_LO = 8,
    parameter int SPB_HI = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  rate_e    rate,
    output tmg_evt_t evt,
    output logic     st
);
    localparam int DIV_W = $clog2(SDIV);
    localparam int IDX_W = $clog2(SPB_LO);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SDIV - 1);
    localparam logic [IDX_W-1:0] LO_LAST  = IDX_W'(SPB_LO - 1);
    localparam logic [IDX_W-1:0] HI_LAST  = IDX_W'(SPB_HI - 1);
    localparam logic [IDX_W-1:0] LO_HALF  = IDX_W'(SPB_LO / 2);
    localparam logic [IDX_W-1:0] HI_HALF  = IDX_W'(SPB_HI / 2);

    logic [DIV_W-1:0] div_cnt;
    logic [IDX_W-1:0] samp_idx, samp_next, last_idx, half_idx;
    logic             en_d, st_q;

    assign last_idx  = (rate == RATE_HI) ? HI_LAST : LO_LAST;
    assign half_idx  = (rate == RATE_HI) ? HI_HALF : LO_HALF;
    assign samp_next = (samp_idx == last_idx) ? '0 : samp_idx + 1'b1;

    always_comb begin
        evt.tick = en && (div_cnt == DIV_LAST);
        evt.mid  = evt.tick && (samp_next == half_idx);
        evt.bnd  = evt.tick && (samp_next == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_cnt  <= '0;
            samp_idx <= '0;
        end else begin
            div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + 1'b1;
            if (evt.tick) samp_idx <= samp_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_d <= 1'b0;
            st_q <= 1'b1;
        end else begin
            en_d <= en;
            if (!en)            st_q <= 1'b1;
            else if (!en_d)     st_q <= 1'b0;
            else if (evt.mid)   st_q <= 1'b1;
            else if (evt.bnd)   st_q <= 1'b0;
        end
    end

    assign st = st_q;

    a_r6_clk_idle_high: assert property (@(posedge clk) disable iff (rst)
        !en |=> st_q);

    a_r2_rise_at_mid: assert property (@(posedge clk) disable iff (rst)
        (en && $rose(st_q)) |-> (samp_idx == half_idx));

    a_r2_fall_at_start: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $fell(st_q)) |-> (samp_idx == '0));

endmodule

// File: rtl/msk_phase.sv
module msk_phase
    import msk_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter logic [PHASE_W-1:0] INC_SPACE   = 16'd8192,
    parameter logic [PHASE_W-1:0] INC_MARK_LO = 16'd12288,
    parameter logic [PHASE_W-1:0] INC_MARK_HI = 16'd16384
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  rate_e              rate,
    input  tmg_evt_t           evt,
    input  logic               din,
    output logic [PHASE_W-1:0] phase
);
    logic               data_hold, bit_cur;
    logic [PHASE_W-1:0] phase_q, step;

    always_comb begin
        if (!bit_cur)              step = INC_SPACE;
        else if (rate == RATE_HI)  step = INC_MARK_HI;
        else                       step = INC_MARK_LO;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            data_hold <= 1'b0;
            bit_cur   <= 1'b0;
            phase_q   <= '0;
        end else begin
            if (evt.mid)  data_hold <= din;
            if (evt.bnd)  bit_cur   <= data_hold;
            if (evt.tick) phase_q   <= phase_q + step;
        end
    end

    assign phase = phase_q;

    a_r5_step_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && (bit_cur != $past(bit_cur))) |-> $past(evt.bnd));

    a_r5_phase_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && !$past(evt.tick)) |-> $stable(phase_q));

endmodule

// File: rtl/msk_sine.sv
module msk_sine
    import msk_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                tick,
    input  logic [PHASE_W-1:0]  phase,
    output logic [SAMPLE_W-1:0] sample,
    output logic                stb
);
    logic [SAMPLE_W-1:0] sample_q;
    logic                stb_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sample_q <= '0;
            stb_q    <= 1'b0;
        end else begin
            stb_q <= tick;
            if (tick) sample_q <= sine_lookup(phase[PHASE_W-1 -: LUT_AW]);
        end
    end

    assign sample = sample_q;
    assign stb    = stb_q;

    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (sample_q == '0 && !stb_q));

    a_r1_strobe_needs_en: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> $past(en));

    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        (en && !stb_q) |-> $stable(sample_q));

endmodule

// File: rtl/msk_tone_mod.sv
module msk_tone_mod
    import msk_pkg::*;
#(
    parameter int CLK_HZ       = 3686400,
    parameter int SAMPLE_HZ    = 9600,
    parameter int BAUD_LO      = 1200,
    parameter int BAUD_HI      = 2400,
    parameter int TONE_SPACE   = 1200,
    parameter int TONE_MARK_LO = 1800,
    parameter int TONE_MARK_HI = 2400,
    parameter int PHASE_W      = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mod_en,
    input  logic                rate_sel,
    input  logic                tx_data,
    output logic                tx_bit_clk,
    output logic [SAMPLE_W-1:0] sample_out,
    output logic                sample_stb
);
    localparam int SDIV   = CLK_HZ / SAMPLE_HZ;
    localparam int SPB_LO = SAMPLE_HZ / BAUD_LO;
    localparam int SPB_HI = SAMPLE_HZ / BAUD_HI;
    localparam logic [PHASE_W-1:0] INC_SPACE   = PHASE_W'((longint'(TONE_SPACE)   << PHASE_W) / SAMPLE_HZ);
    localparam logic [PHASE_W-1:0] INC_MARK_LO = PHASE_W'((longint'(TONE_MARK_LO) << PHASE_W) / SAMPLE_HZ);
    localparam logic [PHASE_W-1:0] INC_MARK_HI = PHASE_W'((longint'(TONE_MARK_HI) << PHASE_W) / SAMPLE_HZ);

    rate_e              rate;
    tmg_evt_t           evt;
    logic [PHASE_W-1:0] phase;

    assign rate = rate_e'(rate_sel);

    msk_timing #(.SDIV(SDIV), .SPB_LO(SPB_LO), .SPB_HI(SPB_HI)) u_timing (
        .clk (clk),
        .rst (rst),
        .en  (mod_en),
        .rate(rate),
        .evt (evt),
        .st  (tx_bit_clk)
    );

    msk_phase #(
        .PHASE_W    (PHASE_W),
        .INC_SPACE  (INC_SPACE),
        .INC_MARK_LO(INC_MARK_LO),
        .INC_MARK_HI(INC_MARK_HI)
    ) u_phase (
        .clk  (clk),
        .rst  (rst),
        .en   (mod_en),
        .rate (rate),
        .evt  (evt),
        .din  (tx_data),
        .phase(phase)
    );

    msk_sine #(.PHASE_W(PHASE_W)) u_sine (
        .clk   (clk),
        .rst   (rst),
        .en    (mod_en),
        .tick  (evt.tick),
        .phase (phase),
        .sample(sample_out),
        .stb   (sample_stb)
    );

    a_r9_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (tx_bit_clk && sample_out == '0 && !sample_stb));

endmodule

// File: tb/tb_msk_tone_mod.sv
`timescale 1ns/1ps
module tb_msk_tone_mod;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mod_en = 1'b0;
    logic       rate_sel = 1'b0;
    logic       tx_data = 1'b0;
    logic       tx_bit_clk;
    logic [7:0] sample_out;
    logic       sample_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    msk_tone_mod dut (
        .clk(clk), .rst(rst), .mod_en(mod_en), .rate_sel(rate_sel),
        .tx_data(tx_data), .tx_bit_clk(tx_bit_clk),
        .sample_out(sample_out), .sample_stb(sample_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_sine(input int ph);
        real v;
        v = 127.0 * $sin(2.0 * 3.14159265358979 * ph / 65536.0);
        return int'(v);
    endfunction

    function automatic int step_of(input bit b, input bit rate);
        int f;
        f = !b ? 1200 : (rate ? 2400 : 1800);
        return (f * 65536) / 9600;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(tx_bit_clk == 1'b1, "R9 bit clock in reset", tx_bit_clk, 1);
        check(sample_out == 8'd0, "R9 sample in reset", sample_out, 0);
        check(sample_stb == 1'b0, "R9 strobe in reset", sample_stb, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // R1 R2 R3 R4 R5 R7 R8: run a bit stream and check every sample against a phase model
    task automatic t_stream(input bit rate, input logic [15:0] bits, input int nbits, input string tag);
        int spb, total, n, ph, k, cyc, last_rise, last_stb, j, bv;
        bit prev_st;
        @(negedge clk);
        mod_en   = 1'b0;
        rate_sel = rate;
        tx_data  = bits[0];
        repeat (2) @(negedge clk);
        mod_en = 1'b1;
        spb = rate ? 4 : 8;
        total = (nbits + 1) * spb;
        n = 0; ph = 0; k = 0; cyc = 0; last_rise = -1; last_stb = -1;
        prev_st = 1'b1;
        while (n < total) begin
            @(negedge clk);
            cyc++;
            if (tx_bit_clk && !prev_st) begin
                if (last_rise >= 0)
                    check(cyc - last_rise == spb * 384, {"R2 bit period ", tag}, cyc - last_rise, spb * 384);
                last_rise = cyc;
                k++;
                tx_data = (k < nbits) ? bits[k] : 1'b0;
            end
            prev_st = tx_bit_clk;
            if (sample_stb) begin
                if (last_stb >= 0)
                    check(cyc - last_stb == 384, {"R1 sample spacing ", tag}, cyc - last_stb, 384);
                last_stb = cyc;
                check($signed(sample_out) == ref_sine(ph),
                      {"R3 R4 R5 R8 sample value ", tag}, $signed(sample_out), ref_sine(ph));
                j  = n / spb;
                bv = (j == 0) ? 0 : int'(bits[j-1]);
                ph = (ph + step_of(bit'(bv), rate)) % 65536;
                n++;
            end
        end
        check(n == total, {"R7 sample count ", tag}, n, total);
        mod_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_disable();
        int stb_seen, low_seen;
        @(negedge clk);
        rate_sel = 1'b0;
        tx_data  = 1'b1;
        mod_en   = 1'b1;
        repeat (5000) @(negedge clk);
        mod_en = 1'b0;
        @(negedge clk);
        check(tx_bit_clk == 1'b1, "R6 bit clock high after disable", tx_bit_clk, 1);
        check(sample_out == 8'd0, "R7 sample zero after disable", sample_out, 0);
        stb_seen = 0; low_seen = 0;
        repeat (1000) begin
            @(negedge clk);
            tx_data = ~tx_data;
            if (sample_stb) stb_seen++;
            if (!tx_bit_clk) low_seen++;
        end
        check(stb_seen == 0, "R7 no strobes while off", stb_seen, 0);
        check(low_seen == 0, "R6 bit clock never low while off", low_seen, 0);
        check(sample_out == 8'd0, "R7 sample stays zero", sample_out, 0);
    endtask

    initial begin
        t_reset();
        t_stream(1'b0, 16'b1011_0010_1101_0110, 12, "lo rate mixed");
        t_stream(1'b1, 16'b1100_1010_0111_0001, 14, "hi rate mixed");
        t_stream(1'b1, 16'hFFFF, 6, "hi rate all ones");
        t_stream(1'b0, 16'h0000, 4, "lo rate all zeros");
        t_disable();
        t_stream(1'b0, 16'b0101_0101_0101_0101, 8, "lo rate alternating after reenable");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule